// File: doc/BRIEF.md
# Dual-Rate FSK Proximity Tag Waveform Generator

This block produces the one-bit coil-modulation stream of an emulated low-frequency proximity tag. The stream is made from two subcarrier cycle shapes. A short cycle lasts 8 samples and a long cycle lasts 10 samples. One sample leaves the block on every rising edge of the carrier-derived clock. A data bit is two half-bits of different cycle types. A short half-bit is six short cycles and a long half-bit is five long cycles. A lone short cycle marks the start of the frame and every nibble boundary.

A 44-bit identifier is presented as a high part and a 32-bit low part. The high part arrives on a 32-bit port, and only its lowest 12 bits may be non-zero. A load pulse while the block is idle latches the identifier and starts the frame at once. The frame repeats without a gap until the stop input is raised. A high part that does not fit in 12 bits raises an error flag and nothing is sent. While idle, the output is held at 1, which leaves the coil open.

Top module: `fsk_tag_emulator`

## Requirements
- R1: After reset, `tx` is 1, `err` is 0 and the block is idle.
- R2: A short cycle is the 8 samples 1,1,0,0,0,0,0,0. A long cycle is the 10 samples 1,1,1,0,0,0,0,0,0,0.
- R3: A short half-bit is 6 short cycles (48 samples) and a long half-bit is 5 long cycles (50 samples). A 1 bit is a long half-bit then a short half-bit. A 0 bit is a short half-bit then a long half-bit.
- R4: A frame opens with one lone short cycle, followed by eight marker half-bits of type short, short, short, long, long, long, short, long.
- R5: The identifier bits follow the marker, most significant first: bits 43..32 from `id_hi[11:0]`, then bits 31..0 from `id_lo`. A lone short cycle comes before each bit whose index within its own part, modulo 4, is 3. That gives 11 such cycles, 12 lone cycles per frame and 540 cycles in all.
- R6: A frame is exactly 4800 samples long, and the next frame starts right after it with no gap.
- R7: A `load` sampled while idle, with `stop` low and `id_hi` at most 0xFFF, latches the identifier and clears `err`. Sample 0 of the frame is on `tx` after that same clock edge.
- R8: A `load` sampled while idle with `id_hi` above 0xFFF sets `err` and starts no frame, so `tx` stays 1. The next accepted load clears `err`.
- R9: When `stop` is sampled high, `tx` is 1 after that edge and the block is idle. `stop` takes priority over a `load` in the same cycle.
- R10: A `load` while a frame is running has no effect. The latched identifier and the sample stream carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-derived sample clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Latch identifier and start when idle |
| stop | input | 1 | Return to idle at the next sample boundary |
| id_hi | input | 32 | High identifier part; only bits 11..0 are legal |
| id_lo | input | 32 | Low identifier part, bits 31..0 of the identifier |
| tx | output | 1 | Coil modulation sample; 1 = coil open |
| err | output | 1 | Last idle load had an out-of-range high part |

## Verification
A wrong sequencer state shows on `tx` no later than the next cycle boundary, as a cycle of the wrong width or the wrong position of its high samples. Over a full frame, any slip in a cycle, half-bit or separator count moves every later sample. That makes the 4800-sample frame comparison, and the check that the second frame matches the first, sensitive to a single missing or extra sample. A wrong control state shows one edge after the stimulus: `tx` not returning high after a stop, `err` not following a rejected or accepted load, or the stream changing after a load while busy.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

    // Position of the generator within one frame
    typedef enum logic [1:0] {
        STG_LEAD = 2'd0,  // lone short cycle opening the frame
        STG_MARK = 2'd1,  // start marker half-bits
        STG_GAP  = 2'd2,  // lone short cycle ahead of a nibble
        STG_DATA = 2'd3   // identifier half-bits
    } fsk_stage_e;

endpackage

// File: rtl/fsk_cycle_shape.sv
module fsk_cycle_shape #(
    parameter int SHORT_LEN  = 8,
    parameter int LONG_LEN   = 10,
    parameter int SHORT_HIGH = 2,
    parameter int LONG_HIGH  = 3,
    parameter int SAMP_W     = $clog2(LONG_LEN)
) (
    input  logic              is_long,
    input  logic [SAMP_W-1:0] samp,
    output logic              level,
    output logic              last
);
    localparam logic [SAMP_W-1:0] S_HI  = SAMP_W'(SHORT_HIGH);
    localparam logic [SAMP_W-1:0] L_HI  = SAMP_W'(LONG_HIGH);
    localparam logic [SAMP_W-1:0] S_END = SAMP_W'(SHORT_LEN - 1);
    localparam logic [SAMP_W-1:0] L_END = SAMP_W'(LONG_LEN - 1);

    always_comb begin
        level = samp < (is_long ? L_HI : S_HI);
        last  = samp == (is_long ? L_END : S_END);
    end
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
    import fsk_tag_pkg::*;
#(
    parameter int ID_W      = 44,
    parameter int LO_W      = 32,
    parameter int NIBBLE    = 4,
    parameter int SHORT_CYC = 6,
    parameter int LONG_CYC  = 5,
    parameter int MARK_LEN  = 8,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 8'b1011_1000,
    parameter int SAMP_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    input  logic [ID_W-1:0]   id,
    input  logic              last,
    output logic              is_long,
    output logic [SAMP_W-1:0] samp
);
    localparam int BIT_W  = $clog2(ID_W);
    localparam int MIDX_W = $clog2(MARK_LEN);
    localparam int CYC_W  = $clog2((SHORT_CYC > LONG_CYC ? SHORT_CYC : LONG_CYC) + 1);
    localparam logic [BIT_W-1:0]  TOP_BIT  = BIT_W'(ID_W - 1);
    localparam logic [MIDX_W-1:0] MARK_END = MIDX_W'(MARK_LEN - 1);
    localparam logic [CYC_W-1:0]  S_CEND   = CYC_W'(SHORT_CYC - 1);
    localparam logic [CYC_W-1:0]  L_CEND   = CYC_W'(LONG_CYC - 1);

    typedef struct packed {
        fsk_stage_e          stage;
        logic [MIDX_W-1:0]   mark_idx;
        logic [BIT_W-1:0]    bit_idx;
        logic                half;
        logic [CYC_W-1:0]    cyc;
        logic [SAMP_W-1:0]   samp;
    } seq_t;

    localparam seq_t START = '{stage: STG_LEAD, mark_idx: '0, bit_idx: TOP_BIT,
                               half: 1'b0, cyc: '0, samp: '0};

    seq_t seq_d, seq_q;
    logic cyc_last;

    // A separator precedes bit k when its index inside its own part is 3 mod nibble
    function automatic logic gap_before(input logic [BIT_W-1:0] k);
        logic [BIT_W-1:0] p;
        p = (k >= BIT_W'(LO_W)) ? k - BIT_W'(LO_W) : k;
        return (p % BIT_W'(NIBBLE)) == BIT_W'(NIBBLE - 1);
    endfunction

    always_comb begin
        unique case (seq_q.stage)
            STG_MARK: is_long = MARK_PAT[seq_q.mark_idx];
            STG_DATA: is_long = id[seq_q.bit_idx] ^ seq_q.half;
            default:  is_long = 1'b0;
        endcase
        cyc_last = seq_q.cyc == (is_long ? L_CEND : S_CEND);
        samp     = seq_q.samp;
    end

    always_comb begin
        seq_d = seq_q;
        if (restart) begin
            seq_d = START;
        end else if (advance) begin
            if (!last) begin
                seq_d.samp = seq_q.samp + 1'b1;
            end else begin
                seq_d.samp = '0;
                seq_d.cyc  = cyc_last ? '0 : seq_q.cyc + 1'b1;
                unique case (seq_q.stage)
                    STG_LEAD: begin
                        seq_d.stage    = STG_MARK;
                        seq_d.mark_idx = '0;
                        seq_d.cyc      = '0;
                    end
                    STG_GAP: begin
                        seq_d.stage = STG_DATA;
                        seq_d.half  = 1'b0;
                        seq_d.cyc   = '0;
                    end
                    STG_MARK: begin
                        if (cyc_last) begin
                            if (seq_q.mark_idx == MARK_END) begin
                                seq_d.bit_idx = TOP_BIT;
                                seq_d.half    = 1'b0;
                                seq_d.stage   = gap_before(TOP_BIT) ? STG_GAP : STG_DATA;
                            end else begin
                                seq_d.mark_idx = seq_q.mark_idx + 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (cyc_last) begin
                            if (!seq_q.half) begin
                                seq_d.half = 1'b1;
                            end else if (seq_q.bit_idx == '0) begin
                                seq_d = START;
                            end else begin
                                seq_d.half    = 1'b0;
                                seq_d.bit_idx = seq_q.bit_idx - 1'b1;
                                seq_d.stage   = gap_before(seq_q.bit_idx - 1'b1) ? STG_GAP : STG_DATA;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= START;
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/fsk_tag_emulator.sv
module fsk_tag_emulator #(
    parameter int HI_IN_W    = 32,
    parameter int HI_W       = 12,
    parameter int LO_W       = 32,
    parameter int NIBBLE     = 4,
    parameter int SHORT_LEN  = 8,
    parameter int LONG_LEN   = 10,
    parameter int SHORT_HIGH = 2,
    parameter int LONG_HIGH  = 3,
    parameter int SHORT_CYC  = 6,
    parameter int LONG_CYC   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               stop,
    input  logic [HI_IN_W-1:0] id_hi,
    input  logic [LO_W-1:0]    id_lo,
    output logic               tx,
    output logic               err
);
    localparam int ID_W   = HI_W + LO_W;
    localparam int SAMP_W = $clog2((SHORT_LEN > LONG_LEN ? SHORT_LEN : LONG_LEN));

    typedef struct packed {
        logic            running;
        logic            err;
        logic [ID_W-1:0] id;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic              accept, out_of_range, restart;
    logic              running;
    logic [ID_W-1:0]   id_q;
    logic              seq_is_long, seq_level, seq_last;
    logic [SAMP_W-1:0] seq_samp;

    always_comb begin
        out_of_range = |id_hi[HI_IN_W-1:HI_W];
        accept       = load && !ctl_q.running && !stop;
        restart      = accept && !out_of_range;
        ctl_d        = ctl_q;
        if (stop) begin
            ctl_d.running = 1'b0;
        end else if (accept) begin
            if (out_of_range) begin
                ctl_d.err = 1'b1;
            end else begin
                ctl_d.err     = 1'b0;
                ctl_d.running = 1'b1;
                ctl_d.id      = {id_hi[HI_W-1:0], id_lo};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign running = ctl_q.running;
    assign id_q    = ctl_q.id;

    fsk_frame_seq #(
        .ID_W(ID_W), .LO_W(LO_W), .NIBBLE(NIBBLE),
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .SAMP_W(SAMP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(ctl_q.running),
        .id(ctl_q.id), .last(seq_last), .is_long(seq_is_long), .samp(seq_samp)
    );

    fsk_cycle_shape #(
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
        .SHORT_HIGH(SHORT_HIGH), .LONG_HIGH(LONG_HIGH), .SAMP_W(SAMP_W)
    ) u_shape (
        .is_long(seq_is_long), .samp(seq_samp), .level(seq_level), .last(seq_last)
    );

    assign tx  = ctl_q.running ? seq_level : 1'b1;
    assign err = ctl_q.err;
endmodule

// File: rtl/fsk_tag_emulator_chk.sv
module fsk_tag_emulator_chk #(
    parameter int HI_IN_W   = 32,
    parameter int HI_W      = 12,
    parameter int ID_W      = 44,
    parameter int SAMP_W    = 4,
    parameter int SHORT_LEN = 8,
    parameter int LONG_LEN  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic               stop,
    input logic [HI_IN_W-1:0] id_hi,
    input logic               tx,
    input logic               err,
    input logic               running,
    input logic [ID_W-1:0]    id_q,
    input logic [SAMP_W-1:0]  samp,
    input logic               is_long
);
    localparam logic [HI_IN_W-1:0] HI_MAX = HI_IN_W'((1 << HI_W) - 1);

    // R1: idle means an open coil
    a_r1_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> tx);

    // R2: sample position stays inside the current cycle shape
    a_r2_samp_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (samp < (is_long ? SAMP_W'(LONG_LEN) : SAMP_W'(SHORT_LEN))));

    // R7: an accepted load starts the frame on its first (high) sample
    a_r7_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !running && !stop && id_hi <= HI_MAX) |=> (running && !err && tx));

    // R8: an out-of-range high part flags and stays idle
    a_r8_reject_range: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !running && !stop && id_hi > HI_MAX) |=> (err && !running && tx));

    // R9: stop returns to idle at the next edge
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!running && tx));

    // R10: identifier is frozen while a frame runs
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !stop) |=> $stable(id_q));
endmodule

bind fsk_tag_emulator fsk_tag_emulator_chk #(
    .HI_IN_W(HI_IN_W), .HI_W(HI_W), .ID_W(ID_W), .SAMP_W(SAMP_W),
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop), .id_hi(id_hi),
    .tx(tx), .err(err), .running(running), .id_q(id_q),
    .samp(seq_samp), .is_long(seq_is_long)
);

// File: tb/test_fsk_tag_emulator.sv
module test_fsk_tag_emulator;
    localparam int FRAME = 4800;
    localparam int NVEC  = 6;
    // {reject, id_hi, id_lo}
    localparam logic [64:0] VEC [0:NVEC-1] = '{
        {1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 32'h0000_1000, 32'h0000_0000},
        {1'b0, 32'h0000_0FFF, 32'hFFFF_FFFF},
        {1'b0, 32'h0000_0A5C, 32'h1234_5678},
        {1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
        {1'b0, 32'h0000_0001, 32'h8000_0001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0, stop = 1'b0;
    logic [31:0] id_hi = '0, id_lo = '0;
    logic tx, err;

    int checks = 0, errors = 0;
    logic exp_f [0:FRAME-1];
    logic got   [0:2*FRAME-1];
    int   n;

    always #5 clk = ~clk;

    fsk_tag_emulator i_fsk_tag_emulator (
        .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
        .id_hi(id_hi), .id_lo(id_lo), .tx(tx), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put(input int ones, input int len);
        for (int j = 0; j < len; j++) begin
            exp_f[n] = (j < ones);
            n++;
        end
    endtask

    task automatic half(input logic lng);
        for (int c = 0; c < (lng ? 5 : 6); c++) put(lng ? 3 : 2, lng ? 10 : 8);
    endtask

    task automatic build(input logic [31:0] hi, input logic [31:0] lo);
        logic [43:0] id;
        id = {hi[11:0], lo};
        n = 0;
        put(2, 8);
        half(0); half(0); half(0); half(1); half(1); half(1); half(0); half(1);
        for (int k = 43; k >= 0; k--) begin
            if ((k % 4) == 3) put(2, 8);
            if (id[k]) begin half(1); half(0); end
            else       begin half(0); half(1); end
        end
    endtask

    task automatic record(input int from, input int cnt);
        for (int i = from; i < from + cnt; i++) begin
            got[i] = tx;
            @(negedge clk);
        end
    endtask

    task automatic frame_checks(input string tag);
        int mism, rep, rises, first_bad;
        mism = 0; rep = 0; rises = 0; first_bad = -1;
        for (int i = 0; i < FRAME; i++) begin
            if (got[i] !== exp_f[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
            if (got[FRAME + i] !== got[i]) rep++;
            if (got[i] && (i == 0 || !got[i-1])) rises++;
        end
        if (mism != 0) $display("  first mismatch at sample %0d", first_bad);
        check({tag, " R2 lead cycle 11000000"},
              {24'b0, got[0], got[1], got[2], got[3], got[4], got[5], got[6], got[7]}, 32'hC0);
        check({tag, " R3 R4 R5 frame content mismatches"}, mism, 0);
        check({tag, " R5 cycle count per frame"}, rises, 540);
        check({tag, " R6 second frame repeats first"}, rep, 0);
    endtask

    task automatic do_stop(input string tag);
        int hi_cnt;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check({tag, " R9 tx high after stop"}, tx, 1);
        hi_cnt = 0;
        for (int i = 0; i < 50; i++) begin
            if (tx === 1'b1) hi_cnt++;
            @(negedge clk);
        end
        check({tag, " R9 stays idle"}, hi_cnt, 50);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset tx", tx, 1);
        check("R1 reset err", err, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle tx after reset", tx, 1);

        for (int v = 0; v < NVEC; v++) begin
            id_hi = VEC[v][63:32];
            id_lo = VEC[v][31:0];
            load  = 1'b1;
            @(negedge clk);
            load  = 1'b0;
            if (VEC[v][64]) begin
                int hi_cnt;
                check($sformatf("vec%0d R8 err set", v), err, 1);
                hi_cnt = 0;
                for (int i = 0; i < 200; i++) begin
                    if (tx === 1'b1) hi_cnt++;
                    @(negedge clk);
                end
                check($sformatf("vec%0d R8 no frame sent", v), hi_cnt, 200);
            end else begin
                check($sformatf("vec%0d R7 R8 err clear", v), err, 0);
                build(VEC[v][63:32], VEC[v][31:0]);
                record(0, 2 * FRAME);
                frame_checks($sformatf("vec%0d", v));
                do_stop($sformatf("vec%0d", v));
            end
        end

        // R10: load while running, with a different identifier
        id_hi = 32'h0000_0C3A; id_lo = 32'hDEAD_BEEF;
        build(id_hi, id_lo);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        record(0, 1000);
        id_hi = 32'h0000_0111; id_lo = 32'h0F0F_0F0F;
        load = 1'b1;
        got[1000] = tx;
        @(negedge clk);
        load = 1'b0;
        record(1001, 2 * FRAME - 1001);
        frame_checks("R10 busy load ignored");
        do_stop("R10");

        // R9: stop has priority over a same-cycle load
        id_hi = 32'h0000_0123; id_lo = 32'h0000_0000;
        stop = 1'b1; load = 1'b1;
        @(negedge clk);
        stop = 1'b0; load = 1'b0;
        begin
            int hi_cnt;
            hi_cnt = 0;
            for (int i = 0; i < 100; i++) begin
                if (tx === 1'b1) hi_cnt++;
                @(negedge clk);
            end
            check("R9 stop beats load, no frame", hi_cnt, 100);
        end
        check("R9 stop beats load, err unchanged", err, 0);

        // R8: rejected load while a previous error cleared, then accepted load
        id_hi = 32'h0000_2000;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R8 err set again", err, 1);
        id_hi = 32'h0000_0000; id_lo = 32'h0000_0005;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R8 err cleared by good load", err, 0);
        check("R7 first sample high", tx, 1);
        do_stop("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule